// File: doc/BRIEF.md
# Flash Write Status Generator

This block forms the status byte that a parallel flash device returns on a read while an internal byte-program or erase job is pending, running or suspended. It does not hold the array and does not time any high-voltage pulse. A command controller drives the current operating mode, the sector-select mask of the erase, bit 7 of the byte being programmed, the erase-window-closed flag, the pulse-limit failure pulse, the reset-command pulse and a flag that says every target sector is locked. From these the block produces three outputs: a status byte, a select flag that tells the read mux whether to return that byte or array data, and a ready/busy level.

The status byte carries several indicators. Bit 7 is a data-polling bit. Bit 6 toggles on every read while a job is live. Bit 2 toggles only on reads that fall inside the sectors chosen for erase. Bit 5 is a sticky failure flag. Bit 3 reports whether the erase accumulation window has closed. Both toggle bits change on the trailing edge of the read strobe, so two back-to-back reads of a live job always return different values.

When every target sector is locked, the job cannot do any work. The block then stays busy for a fixed interval, counted in clock cycles from the clock frequency, and after that releases the read path to array data.

Top module: `flash_wstat_gen`

## Requirements
- R1: Mode code 1 (program) and mode code 4 (program during erase-suspend) drive `stat_byte[7]` to the complement of `prog_top`. Mode code 0 (idle) deasserts `stat_sel`, which hands the read path back to array data.
- R2: Mode code 2 (erase) reads `stat_byte[7]` as 0. Mode code 3 (erase-suspended) reads it as 1 whenever status is selected.
- R3: `stat_byte[6]` inverts one cycle after each strobe trailing edge (a cycle with `rd_stb` low after a cycle with it high) seen while a job is live. A job is live in modes 1, 2 or 4 when the locked interval has not expired. In every other case the bit keeps its value, including idle, erase-suspended and an expired locked interval.
- R4: `stat_byte[2]` inverts after a strobe trailing edge only under two conditions. The mode must be 2 (with the locked interval not expired) or 3. The sector must be set in `sect_mask`, where the sector is the top log2(NSECT) bits of the address held while the strobe was high.
- R5: A `pulse_fail` pulse sets `stat_byte[5]` from the next cycle on. The bit holds until a `clr_cmd` pulse clears it. When both pulses arrive in the same cycle, the set wins.
- R6: `stat_byte[3]` equals `window_closed` in mode 2, reads 1 in mode 3 and reads 0 in every other mode. Bits 4, 1 and 0 are always 0.
- R7: `rdy` is low in modes 1, 2 and 4 while the locked interval has not expired. It is high in modes 0 and 3 and in the unused codes 5 to 7.
- R8: `stat_sel` is 1 while a job is live. In mode 3 it equals the `sect_mask` bit of the sector of the current `rd_addr`. It is 0 otherwise, and `stat_byte` reads 0x00 whenever `stat_sel` is 0.
- R9: The locked interval applies when a mode change into mode 1, 2 or 4 happens with `all_locked` high. The job then stops being live N cycles after the cycle of that change: `rdy` rises and `stat_sel` falls, and both stay so until the mode changes again. N is CLK_MHZ*PROG_US for modes 1 and 4 and CLK_MHZ*ERASE_US for mode 2. With `all_locked` low the job stays live.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_stb | input | 1 | Read strobe, high for the duration of a read |
| rd_addr | input | ADDR_W | Read address; top bits select the sector |
| sect_mask | input | NSECT | Sectors chosen for erase, one bit per sector |
| prog_top | input | 1 | Bit 7 of the byte being programmed |
| op_mode | input | 3 | Operating mode code (0 idle, 1 program, 2 erase, 3 erase-suspended, 4 program in suspend) |
| window_closed | input | 1 | Erase accumulation window has closed |
| pulse_fail | input | 1 | Pulse-count limit exceeded (pulse) |
| clr_cmd | input | 1 | Reset command seen (pulse) |
| all_locked | input | 1 | Every target sector of the job is locked |
| stat_byte | output | 8 | Status byte |
| stat_sel | output | 1 | Return status (1) or array data (0) |
| rdy | output | 1 | Ready (1) / busy (0) |

## Verification
Three pairs of functions can fall in the same cycle. In the first, the strobe trailing edge lands in the very cycle where the mode leaves a live job. The toggle must follow the mode of that cycle, so the bench ends reads right at mode changes and compares bit 6 with its model one cycle later. In the second, the failure set and the reset command arrive together; the bench drives both in one cycle and expects bit 5 to stay set. In the third, the expiry of the locked interval is checked exactly at its boundary, with busy still low one cycle before N and high at N.

// File: rtl/fws_pkg.sv
package fws_pkg;

  typedef enum logic [2:0] {
    MD_IDLE  = 3'd0,
    MD_PROG  = 3'd1,
    MD_ERASE = 3'd2,
    MD_ESUSP = 3'd3,
    MD_SPROG = 3'd4
  } fws_mode_e;

  // Modes in which an internal job drives the device busy.
  function automatic logic mode_is_job(input logic [2:0] m);
    return (m == MD_PROG) || (m == MD_ERASE) || (m == MD_SPROG);
  endfunction

  // Modes in which an erase is pending (running or suspended).
  function automatic logic mode_has_erase(input logic [2:0] m);
    return (m == MD_ERASE) || (m == MD_ESUSP);
  endfunction

  // Data-polling bit for a given mode.
  function automatic logic poll_value(input logic [2:0] m, input logic d7);
    logic v;
    case (m)
      MD_PROG, MD_SPROG: v = ~d7;
      MD_ERASE:          v = 1'b0;
      MD_ESUSP:          v = 1'b1;
      default:           v = d7;
    endcase
    return v;
  endfunction

  // Erase-window indicator for a given mode.
  function automatic logic window_value(input logic [2:0] m, input logic closed);
    logic v;
    case (m)
      MD_ERASE: v = closed;
      MD_ESUSP: v = 1'b1;
      default:  v = 1'b0;
    endcase
    return v;
  endfunction

  // Cycle count of a fixed interval given in microseconds.
  function automatic int guard_cycles(input int mhz, input int us);
    return mhz * us;
  endfunction

  // Width of a down-counter able to hold value n.
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/fws_guard_timer.sv
module fws_guard_timer
  import fws_pkg::*;
#(
  parameter int PROG_CYC  = 200,
  parameter int ERASE_CYC = 10000,
  parameter int CYC_W     = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_mode,
  input  logic       all_locked,
  output logic       guard_over
);

  logic [2:0]       mode_q;
  logic             run_q;
  logic             over_q;
  logic [CYC_W-1:0] cnt_q;
  logic             mode_chg;
  logic [CYC_W-1:0] load_val;
  logic             last_tick;

  assign mode_chg  = (op_mode != mode_q);
  assign load_val  = (op_mode == MD_ERASE) ? CYC_W'(ERASE_CYC - 1)
                                           : CYC_W'(PROG_CYC - 1);
  assign last_tick = run_q && (cnt_q == CYC_W'(1));

  // A fresh mode never inherits an expiry from the previous one.
  assign guard_over = over_q && !mode_chg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MD_IDLE;
      run_q  <= 1'b0;
      over_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      mode_q <= op_mode;
      if (mode_chg) begin
        run_q  <= mode_is_job(op_mode) && all_locked;
        cnt_q  <= load_val;
        over_q <= 1'b0;
      end else if (last_tick) begin
        run_q  <= 1'b0;
        over_q <= 1'b1;
      end else if (run_q) begin
        cnt_q <= cnt_q - CYC_W'(1);
      end
    end
  end

endmodule

// File: rtl/fws_strobe_track.sv
module fws_strobe_track #(
  parameter int NSECT = 16,
  parameter int SEC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_stb,
  input  logic [SEC_W-1:0] live_sec,
  input  logic [NSECT-1:0] sect_mask,
  input  logic             tog6_en,
  input  logic             tog2_ctx,
  output logic             rd_fall,
  output logic             tog6,
  output logic             tog2
);

  logic             rd_q;
  logic [SEC_W-1:0] held_sec;
  logic             held_hit;

  assign rd_fall  = rd_q && !rd_stb;
  assign held_hit = sect_mask[held_sec];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q     <= 1'b0;
      held_sec <= '0;
    end else begin
      rd_q <= rd_stb;
      if (rd_stb) held_sec <= live_sec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog6 <= 1'b0;
      tog2 <= 1'b0;
    end else if (rd_fall) begin
      if (tog6_en)             tog6 <= ~tog6;
      if (tog2_ctx && held_hit) tog2 <= ~tog2;
    end
  end

endmodule

// File: rtl/fws_compose.sv
module fws_compose
  import fws_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] op_mode,
  input  logic       prog_top,
  input  logic       window_closed,
  input  logic       pulse_fail,
  input  logic       clr_cmd,
  input  logic       guard_over,
  input  logic       live_hit,
  input  logic       tog6,
  input  logic       tog2,
  output logic       job_live,
  output logic       tog2_ctx,
  output logic       fail_flag,
  output logic [7:0] stat_byte,
  output logic       stat_sel,
  output logic       rdy
);

  logic [7:0] raw_byte;

  assign job_live = mode_is_job(op_mode) && !guard_over;
  assign tog2_ctx = mode_has_erase(op_mode) && !guard_over;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          fail_flag <= 1'b0;
    else if (pulse_fail) fail_flag <= 1'b1;
    else if (clr_cmd)    fail_flag <= 1'b0;
  end

  always_comb begin
    raw_byte    = 8'h00;
    raw_byte[7] = poll_value(op_mode, prog_top);
    raw_byte[6] = tog6;
    raw_byte[5] = fail_flag;
    raw_byte[3] = window_value(op_mode, window_closed);
    raw_byte[2] = tog2;
  end

  always_comb begin
    if (job_live)                 stat_sel = 1'b1;
    else if (op_mode == MD_ESUSP) stat_sel = live_hit;
    else                          stat_sel = 1'b0;
  end

  assign stat_byte = stat_sel ? raw_byte : 8'h00;
  assign rdy       = !job_live;

endmodule

// File: rtl/flash_wstat_gen.sv
module flash_wstat_gen
  import fws_pkg::*;
#(
  parameter int ADDR_W   = 20,
  parameter int NSECT    = 16,
  parameter int CLK_MHZ  = 100,
  parameter int PROG_US  = 2,
  parameter int ERASE_US = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [NSECT-1:0]  sect_mask,
  input  logic              prog_top,
  input  logic [2:0]        op_mode,
  input  logic              window_closed,
  input  logic              pulse_fail,
  input  logic              clr_cmd,
  input  logic              all_locked,
  output logic [7:0]        stat_byte,
  output logic              stat_sel,
  output logic              rdy
);

  localparam int SEC_W     = $clog2(NSECT);
  localparam int OFS_W     = ADDR_W - SEC_W;
  localparam int PROG_CYC  = guard_cycles(CLK_MHZ, PROG_US);
  localparam int ERASE_CYC = guard_cycles(CLK_MHZ, ERASE_US);
  localparam int MAX_CYC   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CYC_W     = count_width(MAX_CYC);

  logic [SEC_W-1:0] live_sec;
  logic             live_hit;
  logic             guard_over;
  logic             job_live;
  logic             tog2_ctx;
  logic             rd_fall;
  logic             tog6;
  logic             tog2;
  logic             fail_flag;

  assign live_sec = SEC_W'(rd_addr >> OFS_W);
  assign live_hit = sect_mask[live_sec];

  fws_guard_timer #(
    .PROG_CYC (PROG_CYC),
    .ERASE_CYC(ERASE_CYC),
    .CYC_W    (CYC_W)
  ) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_mode   (op_mode),
    .all_locked(all_locked),
    .guard_over(guard_over)
  );

  fws_strobe_track #(
    .NSECT(NSECT),
    .SEC_W(SEC_W)
  ) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .live_sec (live_sec),
    .sect_mask(sect_mask),
    .tog6_en  (job_live),
    .tog2_ctx (tog2_ctx),
    .rd_fall  (rd_fall),
    .tog6     (tog6),
    .tog2     (tog2)
  );

  fws_compose u_compose (
    .clk          (clk),
    .rst_n        (rst_n),
    .op_mode      (op_mode),
    .prog_top     (prog_top),
    .window_closed(window_closed),
    .pulse_fail   (pulse_fail),
    .clr_cmd      (clr_cmd),
    .guard_over   (guard_over),
    .live_hit     (live_hit),
    .tog6         (tog6),
    .tog2         (tog2),
    .job_live     (job_live),
    .tog2_ctx     (tog2_ctx),
    .fail_flag    (fail_flag),
    .stat_byte    (stat_byte),
    .stat_sel     (stat_sel),
    .rdy          (rdy)
  );

endmodule

// File: rtl/fws_chk.sv
module fws_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] op_mode,
  input logic       rd_fall,
  input logic       job_live,
  input logic       guard_over,
  input logic       tog6,
  input logic       fail_flag,
  input logic       clr_cmd,
  input logic [7:0] stat_byte,
  input logic       stat_sel,
  input logic       rdy
);

  a_r3_flip_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fall && job_live |=> tog6 != $past(tog6));

  a_r3_hold_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fall |=> $stable(tog6));

  a_r2_erase_poll_low: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel && op_mode == 3'd2 |-> !stat_byte[7]);

  a_r5_fail_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    fail_flag && !clr_cmd |=> fail_flag);

  a_r7_suspend_ready: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode == 3'd3 |-> rdy);

  a_r7_erase_busy: assert property (@(posedge clk) disable iff (!rst_n)
    op_mode == 3'd2 && !guard_over |-> !rdy);

  a_r8_quiet_byte: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_sel |-> stat_byte == 8'h00);

  a_r9_released: assert property (@(posedge clk) disable iff (!rst_n)
    guard_over |-> rdy && !stat_sel);

endmodule

bind flash_wstat_gen fws_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_mode   (op_mode),
  .rd_fall   (rd_fall),
  .job_live  (job_live),
  .guard_over(guard_over),
  .tog6      (tog6),
  .fail_flag (fail_flag),
  .clr_cmd   (clr_cmd),
  .stat_byte (stat_byte),
  .stat_sel  (stat_sel),
  .rdy       (rdy)
);

// File: tb/flash_wstat_gen_tb.sv
module flash_wstat_gen_tb;

  localparam int P_CYC = 200;    // 100 cycles per us * 2 us
  localparam int E_CYC = 10000;  // 100 cycles per us * 100 us

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rd_stb = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [15:0] sect_mask = '0;
  logic        prog_top = 1'b0;
  logic [2:0]  op_mode = 3'd0;
  logic        window_closed = 1'b0;
  logic        pulse_fail = 1'b0;
  logic        clr_cmd = 1'b0;
  logic        all_locked = 1'b0;
  logic [7:0]  stat_byte;
  logic        stat_sel;
  logic        rdy;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  flash_wstat_gen u_dut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .sect_mask(sect_mask), .prog_top(prog_top), .op_mode(op_mode),
    .window_closed(window_closed), .pulse_fail(pulse_fail), .clr_cmd(clr_cmd),
    .all_locked(all_locked), .stat_byte(stat_byte), .stat_sel(stat_sel), .rdy(rdy));

  // ---------------- behavioural reference ----------------
  bit m_t6, m_t2, m_fail, m_prev_stb, m_locked;
  int m_held_sec, m_prev_mode, m_age;

  function automatic bit is_job(int m);
    return m == 1 || m == 2 || m == 4;
  endfunction

  function automatic bit ref_live();
    int age; bit locked; int lim;
    if (int'(op_mode) != m_prev_mode) begin age = 0; locked = all_locked; end
    else begin age = m_age; locked = m_locked; end
    lim = (op_mode == 3'd2) ? E_CYC : P_CYC;
    return is_job(op_mode) && !(locked && age >= lim);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_t6 = 0; m_t2 = 0; m_fail = 0; m_prev_stb = 0; m_locked = 0;
      m_held_sec = 0; m_prev_mode = 0; m_age = 0;
    end else begin
      bit live;
      live = ref_live();
      if (m_prev_stb && !rd_stb) begin
        if (live) m_t6 = !m_t6;
        if (((op_mode == 3'd2 && live) || op_mode == 3'd3) && sect_mask[m_held_sec])
          m_t2 = !m_t2;
      end
      m_prev_stb = rd_stb;
      if (rd_stb) m_held_sec = int'(rd_addr / 20'h10000);
      if (pulse_fail) m_fail = 1;
      else if (clr_cmd) m_fail = 0;
      if (int'(op_mode) != m_prev_mode) begin
        m_age = 1; m_locked = all_locked;
      end else if (m_age < 1000000) m_age++;
      m_prev_mode = int'(op_mode);
    end
  end

  task automatic ref_outputs(output logic [7:0] eb, output logic es, output logic er);
    bit live;
    live = ref_live();
    if (live) es = 1;
    else if (op_mode == 3'd3) es = sect_mask[rd_addr / 20'h10000];
    else es = 0;
    er = !live;
    eb = 8'h00;
    if (es) begin
      case (op_mode)
        3'd1, 3'd4: eb[7] = !prog_top;
        3'd3:       eb[7] = 1;
        default:    eb[7] = 0;
      endcase
      eb[6] = m_t6;
      eb[5] = m_fail;
      eb[3] = (op_mode == 3'd2) ? window_closed : (op_mode == 3'd3);
      eb[2] = m_t2;
    end
  endtask

  // Compare against the reference every cycle, 3 ns after the falling edge.
  initial begin
    forever begin
      logic [7:0] eb; logic es, er;
      @(negedge clk);
      #3;
      ref_outputs(eb, es, er);
      tests++;
      if (stat_byte !== eb || stat_sel !== es || rdy !== er) begin
        fails++;
        $display("FAIL R1-byte/R2/R3/R4/R5/R6 via model (R7 rdy, R8 sel) at %0t: act byte=%h sel=%b rdy=%b exp byte=%h sel=%b rdy=%b",
                 $time, stat_byte, stat_sel, rdy, eb, es, er);
      end
    end
  end

  // ---------------- directed checks ----------------
  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd_pulse(input logic [19:0] a);
    @(negedge clk); rd_addr = a; rd_stb = 1;
    @(negedge clk); rd_stb = 0;
    @(negedge clk); #3;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk); op_mode = m; #3;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    logic b6_before, b2_before, b6_saved;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #3;
    chk("R7 reset rdy", {7'd0, rdy}, 8'h01);
    chk("R8 reset sel", {7'd0, stat_sel}, 8'h00);
    chk("R8 reset byte", stat_byte, 8'h00);

    // program
    prog_top = 1;
    set_mode(3'd1);
    chk("R1 poll complement of 1", {7'd0, stat_byte[7]}, 8'h00);
    chk("R8 sel in program", {7'd0, stat_sel}, 8'h01);
    chk("R7 busy in program", {7'd0, rdy}, 8'h00);
    @(negedge clk); prog_top = 0; #3;
    chk("R1 poll complement of 0", {7'd0, stat_byte[7]}, 8'h01);
    b6_before = stat_byte[6];
    rd_pulse(20'h00000);
    chk("R3 toggle after read 1", {7'd0, stat_byte[6]}, {7'd0, !b6_before});
    rd_pulse(20'h00000);
    chk("R3 toggle after read 2", {7'd0, stat_byte[6]}, {7'd0, b6_before});
    b6_saved = stat_byte[6];

    // idle: array path, no toggle
    set_mode(3'd0);
    chk("R1 idle hands back array", {7'd0, stat_sel}, 8'h00);
    chk("R7 idle ready", {7'd0, rdy}, 8'h01);
    rd_pulse(20'h00000);

    // erase
    sect_mask = 16'h0005;
    window_closed = 0;
    set_mode(3'd2);
    chk("R3 no toggle while idle", {7'd0, stat_byte[6]}, {7'd0, b6_saved});
    chk("R2 erase poll low", {7'd0, stat_byte[7]}, 8'h00);
    chk("R6 window open", {7'd0, stat_byte[3]}, 8'h00);
    @(negedge clk); window_closed = 1; #3;
    chk("R6 window closed", {7'd0, stat_byte[3]}, 8'h01);
    chk("R6 spare bits zero", stat_byte & 8'h13, 8'h00);
    b2_before = stat_byte[2];
    rd_pulse(20'h20000);
    chk("R4 toggle in selected sector", {7'd0, stat_byte[2]}, {7'd0, !b2_before});
    b2_before = stat_byte[2];
    b6_before = stat_byte[6];
    rd_pulse(20'h10000);
    chk("R4 hold in unselected sector", {7'd0, stat_byte[2]}, {7'd0, b2_before});
    chk("R3 toggle at any address", {7'd0, stat_byte[6]}, {7'd0, !b6_before});

    // erase-suspended
    rd_addr = 20'h00010;
    set_mode(3'd3);
    chk("R2 suspend poll high", {7'd0, stat_byte[7]}, 8'h01);
    chk("R7 suspend ready", {7'd0, rdy}, 8'h01);
    chk("R8 suspend selected sector", {7'd0, stat_sel}, 8'h01);
    chk("R6 suspend window bit", {7'd0, stat_byte[3]}, 8'h01);
    @(negedge clk); rd_addr = 20'h10010; #3;
    chk("R8 suspend other sector", {7'd0, stat_sel}, 8'h00);
    @(negedge clk); rd_addr = 20'h00010; #3;
    b6_before = stat_byte[6];
    b2_before = stat_byte[2];
    rd_pulse(20'h00010);
    chk("R3 no toggle in suspend", {7'd0, stat_byte[6]}, {7'd0, b6_before});
    chk("R4 toggle in suspend", {7'd0, stat_byte[2]}, {7'd0, !b2_before});

    // program during suspend
    prog_top = 1;
    set_mode(3'd4);
    chk("R7 busy in suspend-program", {7'd0, rdy}, 8'h00);
    chk("R1 poll in suspend-program", {7'd0, stat_byte[7]}, 8'h00);

    // failure latch
    @(negedge clk); pulse_fail = 1;
    @(negedge clk); pulse_fail = 0; #3;
    chk("R5 fail set", {7'd0, stat_byte[5]}, 8'h01);
    repeat (3) @(negedge clk);
    #3;
    chk("R5 fail held", {7'd0, stat_byte[5]}, 8'h01);
    @(negedge clk); clr_cmd = 1;
    @(negedge clk); clr_cmd = 0; #3;
    chk("R5 fail cleared", {7'd0, stat_byte[5]}, 8'h00);
    @(negedge clk); clr_cmd = 1; pulse_fail = 1;
    @(negedge clk); clr_cmd = 0; pulse_fail = 0; #3;
    chk("R5 set wins over clear", {7'd0, stat_byte[5]}, 8'h01);
    @(negedge clk); clr_cmd = 1;
    @(negedge clk); clr_cmd = 0;

    // read ending in the same cycle the job ends
    @(negedge clk); rd_stb = 1;
    @(negedge clk); rd_stb = 0; op_mode = 3'd0;
    @(negedge clk); op_mode = 3'd1; #3;

    // unused code
    set_mode(3'd6);
    chk("R7 unused code ready", {7'd0, rdy}, 8'h01);
    chk("R8 unused code no status", {7'd0, stat_sel}, 8'h00);

    // locked program interval
    set_mode(3'd0);
    @(negedge clk); op_mode = 3'd1; all_locked = 1;
    repeat (P_CYC - 1) @(posedge clk);
    #3;
    chk("R9 program still busy at N-1", {7'd0, rdy}, 8'h00);
    @(posedge clk); #3;
    chk("R9 program released at N", {6'd0, stat_sel, rdy}, 8'h01);
    all_locked = 0;

    // locked erase interval
    @(negedge clk); op_mode = 3'd0;
    @(negedge clk); op_mode = 3'd2; all_locked = 1;
    repeat (E_CYC - 1) @(posedge clk);
    #3;
    chk("R9 erase still busy at N-1", {7'd0, rdy}, 8'h00);
    @(posedge clk); #3;
    chk("R9 erase released at N", {6'd0, stat_sel, rdy}, 8'h01);
    all_locked = 0;

    // unlocked program stays busy
    @(negedge clk); op_mode = 3'd0;
    @(negedge clk); op_mode = 3'd1;
    repeat (P_CYC + 50) @(posedge clk);
    #3;
    chk("R9 unlocked stays busy", {7'd0, rdy}, 8'h00);

    set_mode(3'd0);
    repeat (2) @(negedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
    end
  end

endmodule